// File: doc/BRIEF.md
# Parity-Protected Write-Back Sequencer

This block sits on the memory side of a directory controller. It serves write-backs of dirty lines and keeps an XOR parity line in step with each data line it changes. A write-back brings a line address, the new line data and a flag that says whether the requester wants an acknowledge. The sequencer locks the line before it touches memory. It reads the old contents and forms the XOR delta against the incoming line, then writes the new line. It acknowledges early if the requester asked for that. It then reads the parity line, folds the delta into it and writes it back. Only then does it release the lock.

Beside every parity entry the block keeps a one-bit valid marker in a small internal RAM. The marker is cleared on the same edge that accepts a write-back, which is ahead of the data write. It is set again on the edge that completes the parity write. A recovery agent that finds a clear marker knows that parity entry may be torn and cannot be used. The parity line of data address `a` is at `PAR_BASE + (a mod PAR_LINES)`, with `PAR_LINES` a power of two. After reset the block sweeps the marker RAM to the valid state before it takes any work.

The memory port carries one request at a time with a request/ready handshake. Read data returns on `mem_rvalid` a fixed number of cycles after the read is accepted.

Top module: `wbp_seq_top`

## Requirements
- R1: `lock_busy` rises on the cycle after a write-back is accepted. It stays high for every memory access of that write-back and falls on the cycle after the parity write is accepted. `lock_addr` holds the line address while `lock_busy` is high. No memory request is issued while `lock_busy` is low.
- R2: A write-back to data address `a` issues exactly this memory order: a read of `a`, then a write of the new line to `a`. The data write is issued only after the old-data read has returned.
- R3: When `wb_ack_req` was 1 at acceptance, `wb_ack` pulses high for one cycle. The pulse falls after the data write is accepted and before the parity read is issued. When `wb_ack_req` was 0, `wb_ack` stays low.
- R4: After the data write, the parity line `PAR_BASE + (a mod PAR_LINES)` is read and rewritten as old_parity XOR old_data XOR new_data. These are the last two memory operations of the write-back.
- R5: A write-back presented while the sequencer is busy sees `wb_ready` low and is held, not dropped. It is accepted once the lock has cleared, and its parity update composes with the earlier one.
- R6: The marker of the target parity entry reads 0 (untrustworthy) from the cycle after acceptance until the parity write completes. From then on it reads 1. Markers of other parity entries are not changed.
- R7: `mk_valid` returns the marker at index `mk_qaddr` one clock after the index is presented.
- R8: After reset, `wb_ready`, `lock_busy`, `mem_req` and `wb_ack` are low. The block spends `PAR_LINES` cycles setting every marker to 1 and then raises `wb_ready`. `seq_busy` is high whenever the sequencer is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wb_valid | input | 1 | write-back request present |
| wb_ready | output | 1 | sequencer idle and able to accept |
| wb_addr | input | ADDR_W | line address of the write-back |
| wb_data | input | DATA_W | new line contents |
| wb_ack_req | input | 1 | requester wants an acknowledge |
| wb_ack | output | 1 | one-cycle acknowledge after the data write |
| lock_busy | output | 1 | a line is locked against coherence traffic |
| lock_addr | output | ADDR_W | address of the locked line |
| seq_busy | output | 1 | sequencer status, high when not idle |
| mem_req | output | 1 | memory request valid |
| mem_we | output | 1 | memory request is a write |
| mem_addr | output | ADDR_W | memory request address |
| mem_wdata | output | DATA_W | memory write data |
| mem_ready | input | 1 | memory accepts the request |
| mem_rvalid | input | 1 | read data valid |
| mem_rdata | input | DATA_W | read data |
| mk_qaddr | input | PIDX_W | marker query index |
| mk_valid | output | 1 | marker value at the queried index |

## Verification
The bench sweeps every data address in two passes with data patterns computed from the address. The first pass shows that the delta is formed from what memory actually holds. The second pass writes over lines that already changed, and repeats parity groups, so a parity fold that loses a contribution shows up. Requests alternate between asking for and declining an acknowledge, which separates the early acknowledge from silence. The memory grants with a periodic stall, so holding a request differs from issuing it once. Two extra cases cover the marker and the stall. In the first, the parity read is frozen while the marker is queried, which shows a torn entry. In the second, a back-to-back request to the same parity group is held until the lock clears.

// File: rtl/wbp_pkg.sv
package wbp_pkg;

  typedef enum logic [3:0] {
    ST_INIT,
    ST_IDLE,
    ST_RD_OLD,
    ST_WT_OLD,
    ST_WR_NEW,
    ST_ACK,
    ST_RD_PAR,
    ST_WT_PAR,
    ST_WR_PAR
  } seq_state_t;

  function automatic logic state_locked(seq_state_t s);
    return (s != ST_INIT) && (s != ST_IDLE);
  endfunction

endpackage

// File: rtl/wbp_mark_ram.sv
module wbp_mark_ram #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wdata,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);

  logic mem [DEPTH];

  // simple dual-port, synchronous read: infers a block or distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/wbp_fsm.sv
module wbp_fsm
  import wbp_pkg::*;
#(
  parameter int PAR_LINES = 16,
  localparam int PIDX_W = (PAR_LINES > 1) ? $clog2(PAR_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_valid,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  output seq_state_t        state,
  output logic              accept,
  output logic              old_take,
  output logic              par_take,
  output logic              par_done,
  output logic              init_we,
  output logic [PIDX_W-1:0] init_idx
);

  localparam logic [PIDX_W-1:0] LAST_IDX = PIDX_W'(PAR_LINES - 1);

  seq_state_t nxt;
  logic [PIDX_W-1:0] init_cnt;

  assign accept   = (state == ST_IDLE) && wb_valid;
  assign old_take = (state == ST_WT_OLD) && mem_rvalid;
  assign par_take = (state == ST_WT_PAR) && mem_rvalid;
  assign par_done = (state == ST_WR_PAR) && mem_ready;
  assign init_we  = (state == ST_INIT);
  assign init_idx = init_cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_INIT:   if (init_cnt == LAST_IDX) nxt = ST_IDLE;
      ST_IDLE:   if (wb_valid) nxt = ST_RD_OLD;
      ST_RD_OLD: if (mem_ready) nxt = ST_WT_OLD;
      ST_WT_OLD: if (mem_rvalid) nxt = ST_WR_NEW;
      ST_WR_NEW: if (mem_ready) nxt = ST_ACK;
      ST_ACK:    nxt = ST_RD_PAR;
      ST_RD_PAR: if (mem_ready) nxt = ST_WT_PAR;
      ST_WT_PAR: if (mem_rvalid) nxt = ST_WR_PAR;
      ST_WR_PAR: if (mem_ready) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_INIT;
      init_cnt <= '0;
    end else begin
      state <= nxt;
      if (state == ST_INIT) init_cnt <= init_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wbp_datapath.sv
module wbp_datapath
  import wbp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PAR_LINES = 16,
  parameter int PAR_BASE  = 128,
  localparam int PIDX_W = (PAR_LINES > 1) ? $clog2(PAR_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_t        state,
  input  logic              accept,
  input  logic              old_take,
  input  logic              par_take,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_ack_req,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] line_addr,
  output logic [PIDX_W-1:0] line_pidx,
  output logic              ack_wanted,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);

  localparam logic [ADDR_W-1:0] PBASE = ADDR_W'(PAR_BASE);

  logic [DATA_W-1:0] new_q, delta_q, par_q;
  logic [ADDR_W-1:0] par_addr;

  assign line_pidx = line_addr[PIDX_W-1:0];
  assign par_addr  = PBASE + {{(ADDR_W-PIDX_W){1'b0}}, line_pidx};

  always_ff @(posedge clk) begin
    if (rst) begin
      line_addr  <= '0;
      new_q      <= '0;
      ack_wanted <= 1'b0;
      delta_q    <= '0;
      par_q      <= '0;
    end else begin
      if (accept) begin
        line_addr  <= wb_addr;
        new_q      <= wb_data;
        ack_wanted <= wb_ack_req;
      end
      // delta of old and new line, formed before the data write
      if (old_take) delta_q <= mem_rdata ^ new_q;
      // delta folded into the parity line
      if (par_take) par_q <= mem_rdata ^ delta_q;
    end
  end

  always_comb begin
    mem_addr  = line_addr;
    mem_wdata = new_q;
    mem_we    = 1'b0;
    unique case (state)
      ST_WR_NEW: mem_we = 1'b1;
      ST_RD_PAR, ST_WT_PAR: mem_addr = par_addr;
      ST_WR_PAR: begin
        mem_addr  = par_addr;
        mem_wdata = par_q;
        mem_we    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wbp_seq_top.sv
module wbp_seq_top
  import wbp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PAR_LINES = 16,
  parameter int PAR_BASE  = 128,
  localparam int PIDX_W = (PAR_LINES > 1) ? $clog2(PAR_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_valid,
  output logic              wb_ready,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_ack_req,
  output logic              wb_ack,
  output logic              lock_busy,
  output logic [ADDR_W-1:0] lock_addr,
  output logic              seq_busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [PIDX_W-1:0] mk_qaddr,
  output logic              mk_valid
);

  seq_state_t        state;
  logic              accept, old_take, par_take, par_done, init_we;
  logic [PIDX_W-1:0] init_idx, line_pidx;
  logic [ADDR_W-1:0] line_addr;
  logic              ack_wanted;
  logic              mk_we, mk_wval;
  logic [PIDX_W-1:0] mk_waddr;

  wbp_fsm #(.PAR_LINES(PAR_LINES)) u_fsm (
    .clk(clk), .rst(rst), .wb_valid(wb_valid),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .state(state), .accept(accept), .old_take(old_take),
    .par_take(par_take), .par_done(par_done),
    .init_we(init_we), .init_idx(init_idx)
  );

  wbp_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PAR_LINES(PAR_LINES), .PAR_BASE(PAR_BASE)
  ) u_dp (
    .clk(clk), .rst(rst), .state(state), .accept(accept),
    .old_take(old_take), .par_take(par_take),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack_req(wb_ack_req),
    .mem_rdata(mem_rdata), .line_addr(line_addr), .line_pidx(line_pidx),
    .ack_wanted(ack_wanted), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we)
  );

  // marker writes: sweep to 1 after reset, clear on accept, set on parity done
  always_comb begin
    mk_we    = 1'b0;
    mk_wval  = 1'b1;
    mk_waddr = line_pidx;
    if (init_we) begin
      mk_we    = 1'b1;
      mk_waddr = init_idx;
    end else if (accept) begin
      mk_we    = 1'b1;
      mk_wval  = 1'b0;
      mk_waddr = wb_addr[PIDX_W-1:0];
    end else if (par_done) begin
      mk_we = 1'b1;
    end
  end

  wbp_mark_ram #(.DEPTH(PAR_LINES)) u_mark (
    .clk(clk), .we(mk_we), .waddr(mk_waddr), .wdata(mk_wval),
    .raddr(mk_qaddr), .rdata(mk_valid)
  );

  assign wb_ready  = (state == ST_IDLE);
  assign seq_busy  = (state != ST_IDLE);
  assign lock_busy = state_locked(state);
  assign lock_addr = line_addr;
  assign wb_ack    = (state == ST_ACK) && ack_wanted;
  assign mem_req   = (state == ST_RD_OLD) || (state == ST_WR_NEW) ||
                     (state == ST_RD_PAR) || (state == ST_WR_PAR);

endmodule

// File: rtl/wbp_seq_chk.sv
module wbp_seq_chk #(
  parameter int ADDR_W   = 8,
  parameter int PAR_BASE = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic              wb_ack,
  input logic              lock_busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr
);

  localparam logic [ADDR_W-1:0] PBASE = ADDR_W'(PAR_BASE);

  // R1
  req_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> lock_busy);

  // R1
  lock_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_busy) |-> $past(wb_valid && wb_ready));

  // R4
  lock_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_busy) |-> $past(mem_req && mem_we && mem_ready && (mem_addr >= PBASE)));

  // R3
  ack_in_lock_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> (lock_busy && !mem_req));

  // R5
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    lock_busy |-> !wb_ready);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind wbp_seq_top wbp_seq_chk #(.ADDR_W(ADDR_W), .PAR_BASE(PAR_BASE)) i_chk (
  .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_ready(wb_ready),
  .wb_ack(wb_ack), .lock_busy(lock_busy), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr)
);

// File: tb/test_wbp_seq_top.sv
`timescale 1ns/1ps
module test_wbp_seq_top;

  localparam int AW = 6, DW = 16, PL = 4, PB = 32, PW = 2, LAT = 2;

  logic clk = 0, rst = 1;
  logic wb_valid = 0, wb_ack_req = 0;
  logic [AW-1:0] wb_addr = '0;
  logic [DW-1:0] wb_data = '0;
  logic wb_ready, wb_ack, lock_busy, seq_busy, mem_req, mem_we, mk_valid;
  logic [AW-1:0] lock_addr, mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ready = 0, mem_rvalid = 0;
  logic [DW-1:0] mem_rdata = '0;
  logic [PW-1:0] mk_qaddr = '0;

  always #2.5 clk = ~clk;

  wbp_seq_top #(.ADDR_W(AW), .DATA_W(DW), .PAR_LINES(PL), .PAR_BASE(PB)) i_wbp_seq_top (
    .clk(clk), .rst(rst), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_ack_req(wb_ack_req),
    .wb_ack(wb_ack), .lock_busy(lock_busy), .lock_addr(lock_addr),
    .seq_busy(seq_busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mk_qaddr(mk_qaddr), .mk_valid(mk_valid)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] mem [64];
  logic [DW-1:0] sh  [64];
  int rd_cnt = 0;
  logic [DW-1:0] rd_hold;
  bit hold_par = 0;
  int lg_kind [16];
  int lg_addr [16];
  int lg_n = 0;
  bit lg_lockbad = 0;

  function automatic logic [DW-1:0] init_word(int i);
    return DW'(i * 16'h1357) ^ 16'hA5A5;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model and operation log, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    mem_rvalid = 0;
    if (rd_cnt == 1) begin
      mem_rvalid = 1;
      mem_rdata  = rd_hold;
    end
    if (rd_cnt > 0) rd_cnt--;
    mem_ready = !rst && (cyc % 3 != 0) &&
                !(hold_par && mem_req && !mem_we && mem_addr >= AW'(PB));
    if (mem_req && mem_ready) begin
      if (lg_n < 16) begin
        lg_kind[lg_n] = mem_we ? 1 : 0;
        lg_addr[lg_n] = int'(mem_addr);
        lg_n++;
      end
      if (!lock_busy || lock_addr != wb_addr) lg_lockbad = 1;
      if (mem_we) mem[mem_addr] = mem_wdata;
      else begin
        rd_cnt  = LAT;
        rd_hold = mem[mem_addr];
      end
    end
    if (wb_ack && lg_n < 16) begin
      lg_kind[lg_n] = 2;
      lg_addr[lg_n] = 0;
      lg_n++;
    end
  end

  task automatic present(int a, logic [DW-1:0] d, bit k);
    wb_addr = AW'(a); wb_data = d; wb_ack_req = k; wb_valid = 1;
    while (!wb_ready) @(negedge clk);
    @(negedge clk);
    wb_valid = 0;
  endtask

  task automatic wait_idle();
    while (lock_busy) @(negedge clk);
  endtask

  task automatic marker_is(int idx, bit exp, string req);
    mk_qaddr = PW'(idx);
    @(negedge clk);
    @(negedge clk);
    chk(mk_valid == exp, req, int'(mk_valid), int'(exp));
  endtask

  task automatic one_wb(int a, logic [DW-1:0] d, bit k);
    int p;
    int lock_cycles;
    logic [DW-1:0] ep;
    p = PB + (a % PL);
    lg_n = 0; lg_lockbad = 0;
    present(a, d, k);
    // R1: accepted on the edge before this negedge, lock already up
    chk(lock_busy == 1 && lock_addr == AW'(a), "R1 lock raised", int'(lock_addr), a);
    lock_cycles = 0;
    while (lock_busy) begin lock_cycles++; @(negedge clk); end
    chk(!lg_lockbad, "R1 lock held over accesses", int'(lg_lockbad), 0);
    chk(lg_n == (k ? 5 : 4), "R3 op count with ack", lg_n, k ? 5 : 4);
    chk(lg_kind[0] == 0 && lg_addr[0] == a && lg_kind[1] == 1 && lg_addr[1] == a,
        "R2 read old then write new", lg_addr[1], a);
    if (k) chk(lg_kind[2] == 2, "R3 ack between data and parity", lg_kind[2], 2);
    chk(lg_kind[lg_n-2] == 0 && lg_addr[lg_n-2] == p &&
        lg_kind[lg_n-1] == 1 && lg_addr[lg_n-1] == p,
        "R4 parity read then write last", lg_addr[lg_n-1], p);
    ep = sh[p] ^ sh[a] ^ d;
    sh[a] = d; sh[p] = ep;
    chk(mem[a] == d, "R2 data line", int'(mem[a]), int'(d));
    chk(mem[p] == ep, "R4 parity line", int'(mem[p]), int'(ep));
    marker_is(a % PL, 1'b1, "R6 marker set after done");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = init_word(i);
      sh[i]  = init_word(i);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R8 reset state, one cycle into the marker sweep
    @(negedge clk);
    chk(!wb_ready && !lock_busy && !mem_req && !wb_ack && seq_busy,
        "R8 reset outputs", int'({wb_ready, lock_busy, mem_req, wb_ack, seq_busy}), 1);
    repeat (PL) @(negedge clk);
    chk(wb_ready && !seq_busy, "R8 ready after sweep", int'(wb_ready), 1);
    for (int i = 0; i < PL; i++) marker_is(i, 1'b1, "R7 R8 marker swept");

    // sweep all data addresses, two passes
    for (int pass = 0; pass < 2; pass++)
      for (int a = 0; a < PB; a++)
        one_wb(a, DW'(a * 16'h00B3 + pass * 16'h7121) ^ 16'h5A3C, (a + pass) % 2 == 1);

    // R6 torn parity: freeze parity read, marker must read 0
    hold_par = 1;
    present(5, 16'hBEEF, 1'b1);
    while (!(mem_req && !mem_we && mem_addr >= AW'(PB))) @(negedge clk);
    marker_is(5 % PL, 1'b0, "R6 marker clear mid-update");
    marker_is(6 % PL, 1'b1, "R6 other marker untouched");
    chk(lock_busy == 1, "R1 lock held while parity stalled", int'(lock_busy), 1);
    hold_par = 0;
    wait_idle();
    begin
      logic [DW-1:0] ep;
      ep = sh[PB+1] ^ sh[5] ^ 16'hBEEF;
      sh[5] = 16'hBEEF; sh[PB+1] = ep;
    end
    chk(mem[PB+1] == sh[PB+1], "R4 parity after stall", int'(mem[PB+1]), int'(sh[PB+1]));
    marker_is(1, 1'b1, "R6 marker set after stall");

    // R5 back-to-back requests in one parity group
    begin
      int held;
      logic [DW-1:0] ep;
      held = 0;
      present(9, 16'h1234, 1'b0);
      wb_addr = AW'(13); wb_data = 16'h4321; wb_ack_req = 0; wb_valid = 1;
      while (lock_busy && lock_addr == AW'(9)) begin
        if (wb_ready) held++;
        @(negedge clk);
      end
      chk(held == 0, "R5 ready low while busy", held, 0);
      while (!wb_ready) @(negedge clk);
      @(negedge clk);
      wb_valid = 0;
      chk(lock_busy && lock_addr == AW'(13), "R5 held request taken", int'(lock_addr), 13);
      wait_idle();
      ep = sh[PB+1] ^ sh[9] ^ 16'h1234 ^ sh[13] ^ 16'h4321;
      sh[9] = 16'h1234; sh[13] = 16'h4321; sh[PB+1] = ep;
      chk(mem[13] == 16'h4321, "R5 held data written", int'(mem[13]), 16'h4321);
      chk(mem[PB+1] == ep, "R5 composed parity", int'(mem[PB+1]), int'(ep));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule